// File: doc/BRIEF.md
# DMA Channel Address and Count Register File

This block keeps, for each of four DMA channels, a 16-bit base address, a 16-bit base count, a live current address and a live transfer position. Software programs it one byte at a time through an 8-bit I/O port. A single shared byte pointer decides whether an access reaches the low byte or the high byte of the selected register, and it inverts after every accepted access. Reads return the live state of the channel. The address read is the current address moved by the position, either up or down. The count read is the number of units left.

A transfer engine outside the block advances each channel. It does this through per-channel load hooks for the position and the current address. It also supplies each channel's direction bit and reads back the current address, the position and the base count. The parameter `SHIFT` picks the width: 0 gives a byte-wide controller, and 1 gives a word-wide controller. In the word-wide case the port index is taken from the port number shifted right by one, and the stored values are scaled by two.

Top module: `dma_chan_regfile`

## Requirements
- R1: The index is `(io_port >> SHIFT) & 0xF`. Index bit 0 selects the address register (0) or the count register (1). Index bits 2:1 give the channel. An access with index bit 3 set is ignored: no register changes, the byte pointer keeps its value and `rd_valid` stays low.
- R2: Every accepted access (`io_en` with a valid index) uses the byte pointer's present value and then inverts it. Value 0 selects bits 7:0 and value 1 selects bits 15:8.
- R3: `ff_clr` forces the byte pointer to 0 on the next edge. If an access arrives in the same cycle, it still uses the old pointer value, but the clear wins over the inversion.
- R4: A low-byte write (`io_wr`=1, pointer 0) replaces bits 7:0 of the selected base register, keeps bits 15:8, and leaves the current address and the position unchanged.
- R5: A high-byte write replaces bits 15:8 of the selected base register and keeps bits 7:0. On the same edge it loads the channel's current address with the updated base address shifted left by `SHIFT`, and it clears the channel's position to 0. This happens whichever register was written.
- R6: An address read returns current address + position when the channel's `dir_down` bit is 0, and current address − position when it is 1.
- R7: A count read returns (base count << `SHIFT`) − position.
- R8: The read byte is bits `SHIFT+8*ptr` upward, 8 bits wide, of the value from R6 or R7. It appears on `rd_data` one edge after the read cycle, with `rd_valid` high for that one cycle. `rd_data` holds its value otherwise.
- R9: `pos_we[c]` loads `pos_in` slice c into the position, and `addr_we[c]` loads `addr_in` slice c into the current address, on the next edge. A high-byte write to the same channel in the same cycle takes priority over both.
- R10: Synchronous `rst` clears all base registers, current addresses, positions, the byte pointer, `rd_data` and `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_en | input | 1 | I/O access strobe, one cycle per byte |
| io_wr | input | 1 | 1 for a write, 0 for a read |
| io_port | input | PORT_W | Port number |
| io_wdata | input | 8 | Write byte |
| ff_clr | input | 1 | Byte pointer clear pulse |
| dir_down | input | 4 | Per-channel direction, 1 = decrementing |
| pos_we | input | 4 | Per-channel position load |
| pos_in | input | 4*POS_W | Per-channel position values |
| addr_we | input | 4 | Per-channel current address load |
| addr_in | input | 4*CUR_W | Per-channel current address values |
| rd_data | output | 8 | Registered read byte |
| rd_valid | output | 1 | Read byte valid pulse |
| cur_addr_o | output | 4*CUR_W | Per-channel current address |
| pos_o | output | 4*POS_W | Per-channel transfer position |
| base_cnt_o | output | 64 | Per-channel base count |

## Verification
A write-then-read sequence runs across three channels with distinct bytes. It shows whether the channel and register decode is correct and whether the byte pointer alternates low and high in step for both access types. After that, the position hook is set with `dir_down` at 0 and then at 1, and the count register is read. These cases separate the increment, decrement and remaining-count arithmetic. Directed cases then fire `ff_clr` between the two halves of a read and access an index with bit 3 set. They also do a lone low-byte write to check that the other byte is kept, a high-byte write to check the reload of the current registers, and a high-byte write in the same cycle as a position hook to check the priority.

// File: rtl/dma_regfile_pkg.sv
package dma_regfile_pkg;
  localparam int NUM_CH = 4;
  localparam int CH_W   = 2;
  localparam int BYTE_W = 8;
  localparam int BASE_W = 16;

  typedef enum logic {
    SEL_ADDR  = 1'b0,
    SEL_COUNT = 1'b1
  } reg_sel_e;

  typedef struct packed {
    logic              valid;
    logic              wr;
    logic [CH_W-1:0]   ch;
    reg_sel_e          sel;
    logic [BYTE_W-1:0] data;
  } access_t;
endpackage

// File: rtl/dma_port_decode.sv
module dma_port_decode
  import dma_regfile_pkg::*;
#(
  parameter int SHIFT  = 0,
  parameter int PORT_W = 8
) (
  input  logic              io_en,
  input  logic              io_wr,
  input  logic [PORT_W-1:0] io_port,
  input  logic [BYTE_W-1:0] io_wdata,
  output access_t           acc
);
  localparam int IDX_W = 4;

  logic [PORT_W-1:0] shifted;
  logic [IDX_W-1:0]  idx;

  always_comb begin
    shifted   = io_port >> SHIFT;
    idx       = shifted[IDX_W-1:0];
    acc.valid = io_en && !idx[3];
    acc.wr    = io_wr;
    acc.ch    = idx[2:1];
    acc.sel   = reg_sel_e'(idx[0]);
    acc.data  = io_wdata;
  end
endmodule

// File: rtl/dma_byte_ptr.sv
module dma_byte_ptr (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic step,
  output logic ptr_q
);
  always_ff @(posedge clk) begin
    if (rst || clr) ptr_q <= 1'b0;
    else if (step)  ptr_q <= ~ptr_q;
  end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_regfile_pkg::*;
#(
  parameter int SHIFT = 0,
  parameter int CUR_W = BASE_W + SHIFT,
  parameter int POS_W = BASE_W + SHIFT + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              hi,
  input  reg_sel_e          sel,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              pos_we,
  input  logic [POS_W-1:0]  pos_in,
  input  logic              addr_we,
  input  logic [CUR_W-1:0]  addr_in,
  output logic [BASE_W-1:0] base_addr,
  output logic [BASE_W-1:0] base_cnt,
  output logic [CUR_W-1:0]  cur_addr,
  output logic [POS_W-1:0]  pos
);
  logic [BASE_W-1:0] merged;
  logic [BASE_W-1:0] next_base_addr;
  logic [BASE_W-1:0] next_base_cnt;
  logic              reload;

  always_comb begin
    merged = (sel == SEL_ADDR) ? base_addr : base_cnt;
    if (hi) merged[BASE_W-1:BYTE_W] = wdata;
    else    merged[BYTE_W-1:0]      = wdata;
    next_base_addr = (wr_en && sel == SEL_ADDR)  ? merged : base_addr;
    next_base_cnt  = (wr_en && sel == SEL_COUNT) ? merged : base_cnt;
    reload = wr_en && hi;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_addr <= '0;
      base_cnt  <= '0;
      cur_addr  <= '0;
      pos       <= '0;
    end else begin
      base_addr <= next_base_addr;
      base_cnt  <= next_base_cnt;
      if (reload) begin
        cur_addr <= CUR_W'(next_base_addr) << SHIFT;
        pos      <= '0;
      end else begin
        if (addr_we) cur_addr <= addr_in;
        if (pos_we)  pos      <= pos_in;
      end
    end
  end
endmodule

// File: rtl/dma_read_mux.sv
module dma_read_mux
  import dma_regfile_pkg::*;
#(
  parameter int SHIFT = 0,
  parameter int CUR_W = BASE_W + SHIFT,
  parameter int POS_W = BASE_W + SHIFT + 1
) (
  input  reg_sel_e          sel,
  input  logic              hi,
  input  logic              dir_down,
  input  logic [CUR_W-1:0]  cur_addr,
  input  logic [POS_W-1:0]  pos,
  input  logic [BASE_W-1:0] base_cnt,
  output logic [BYTE_W-1:0] rbyte
);
  localparam int VAL_W = 32;

  logic [VAL_W-1:0] addr_val;
  logic [VAL_W-1:0] cnt_val;
  logic [VAL_W-1:0] val;
  logic [VAL_W-1:0] moved;

  always_comb begin
    addr_val = dir_down ? (VAL_W'(cur_addr) - VAL_W'(pos))
                        : (VAL_W'(cur_addr) + VAL_W'(pos));
    cnt_val  = (VAL_W'(base_cnt) << SHIFT) - VAL_W'(pos);
    val      = (sel == SEL_ADDR) ? addr_val : cnt_val;
    moved    = val >> (SHIFT + (hi ? BYTE_W : 0));
    rbyte    = moved[BYTE_W-1:0];
  end
endmodule

// File: rtl/dma_chan_regfile.sv
module dma_chan_regfile
  import dma_regfile_pkg::*;
#(
  parameter int SHIFT  = 0,
  parameter int PORT_W = 8,
  localparam int CUR_W = BASE_W + SHIFT,
  localparam int POS_W = BASE_W + SHIFT + 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     io_en,
  input  logic                     io_wr,
  input  logic [PORT_W-1:0]        io_port,
  input  logic [BYTE_W-1:0]        io_wdata,
  input  logic                     ff_clr,
  input  logic [NUM_CH-1:0]        dir_down,
  input  logic [NUM_CH-1:0]        pos_we,
  input  logic [NUM_CH*POS_W-1:0]  pos_in,
  input  logic [NUM_CH-1:0]        addr_we,
  input  logic [NUM_CH*CUR_W-1:0]  addr_in,
  output logic [BYTE_W-1:0]        rd_data,
  output logic                     rd_valid,
  output logic [NUM_CH*CUR_W-1:0]  cur_addr_o,
  output logic [NUM_CH*POS_W-1:0]  pos_o,
  output logic [NUM_CH*BASE_W-1:0] base_cnt_o
);
  access_t           acc;
  logic              ptr_q;
  logic [BYTE_W-1:0] rbyte;

  logic [CUR_W-1:0]  cur_arr  [NUM_CH];
  logic [POS_W-1:0]  pos_arr  [NUM_CH];
  logic [BASE_W-1:0] bcnt_arr [NUM_CH];
  logic [BASE_W-1:0] badr_arr [NUM_CH];

  dma_port_decode #(.SHIFT(SHIFT), .PORT_W(PORT_W)) u_dec (
    .io_en    (io_en),
    .io_wr    (io_wr),
    .io_port  (io_port),
    .io_wdata (io_wdata),
    .acc      (acc)
  );

  dma_byte_ptr u_ptr (
    .clk   (clk),
    .rst   (rst),
    .clr   (ff_clr),
    .step  (acc.valid),
    .ptr_q (ptr_q)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dma_chan_regs #(.SHIFT(SHIFT), .CUR_W(CUR_W), .POS_W(POS_W)) u_regs (
      .clk       (clk),
      .rst       (rst),
      .wr_en     (acc.valid && acc.wr && (acc.ch == CH_W'(c))),
      .hi        (ptr_q),
      .sel       (acc.sel),
      .wdata     (acc.data),
      .pos_we    (pos_we[c]),
      .pos_in    (pos_in[c*POS_W +: POS_W]),
      .addr_we   (addr_we[c]),
      .addr_in   (addr_in[c*CUR_W +: CUR_W]),
      .base_addr (badr_arr[c]),
      .base_cnt  (bcnt_arr[c]),
      .cur_addr  (cur_arr[c]),
      .pos       (pos_arr[c])
    );
    assign cur_addr_o[c*CUR_W +: CUR_W]  = cur_arr[c];
    assign pos_o[c*POS_W +: POS_W]       = pos_arr[c];
    assign base_cnt_o[c*BASE_W +: BASE_W] = bcnt_arr[c];
  end

  dma_read_mux #(.SHIFT(SHIFT), .CUR_W(CUR_W), .POS_W(POS_W)) u_mux (
    .sel      (acc.sel),
    .hi       (ptr_q),
    .dir_down (dir_down[acc.ch]),
    .cur_addr (cur_arr[acc.ch]),
    .pos      (pos_arr[acc.ch]),
    .base_cnt (bcnt_arr[acc.ch]),
    .rbyte    (rbyte)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= acc.valid && !acc.wr;
      if (acc.valid && !acc.wr) rd_data <= rbyte;
    end
  end
endmodule

// File: rtl/dma_regfile_chk.sv
module dma_regfile_chk
  import dma_regfile_pkg::*;
#(
  parameter int SHIFT = 0,
  parameter int POS_W = BASE_W + SHIFT + 1,
  parameter int CUR_W = BASE_W + SHIFT
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    io_en,
  input logic                    ff_clr,
  input logic                    ptr_q,
  input access_t                 acc,
  input logic                    rd_valid,
  input logic [NUM_CH*POS_W-1:0] pos_o,
  input logic [NUM_CH*CUR_W-1:0] cur_addr_o
);
  AST_IGNORED_INDEX: assert property (@(posedge clk) disable iff (rst)
    (io_en && !acc.valid && !ff_clr) |=> ($stable(ptr_q) && !rd_valid)); // R1

  AST_PTR_STEPS: assert property (@(posedge clk) disable iff (rst)
    (acc.valid && !ff_clr) |=> (ptr_q != $past(ptr_q))); // R2

  AST_CLR_WINS: assert property (@(posedge clk) disable iff (rst)
    ff_clr |=> !ptr_q); // R3

  AST_HIGH_RELOADS: assert property (@(posedge clk) disable iff (rst)
    (acc.valid && acc.wr && ptr_q) |=> (pos_o[$past(acc.ch)*POS_W +: POS_W] == '0)); // R5

  AST_READ_PULSE: assert property (@(posedge clk) disable iff (rst)
    (acc.valid && !acc.wr) |=> rd_valid); // R8

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!rd_valid && !ptr_q && cur_addr_o == '0 && pos_o == '0)); // R10
endmodule

bind dma_chan_regfile dma_regfile_chk #(.SHIFT(SHIFT)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .io_en      (io_en),
  .ff_clr     (ff_clr),
  .ptr_q      (ptr_q),
  .acc        (acc),
  .rd_valid   (rd_valid),
  .pos_o      (pos_o),
  .cur_addr_o (cur_addr_o)
);

// File: tb/tb_dma_chan_regfile.sv
module tb_dma_chan_regfile;
  localparam int SHIFT = 0;
  localparam int CUR_W = 16 + SHIFT;
  localparam int POS_W = 17 + SHIFT;
  localparam int NV    = 22;

  // {write, port, data, expected read byte}
  localparam logic [24:0] VEC [NV] = '{
    {1'b1, 8'h00, 8'h34, 8'h00}, {1'b1, 8'h00, 8'h12, 8'h00},
    {1'b1, 8'h01, 8'h10, 8'h00}, {1'b1, 8'h01, 8'h00, 8'h00},
    {1'b0, 8'h00, 8'h00, 8'h34}, {1'b0, 8'h00, 8'h00, 8'h12},
    {1'b0, 8'h01, 8'h00, 8'h10}, {1'b0, 8'h01, 8'h00, 8'h00},
    {1'b1, 8'h04, 8'hCD, 8'h00}, {1'b1, 8'h04, 8'hAB, 8'h00},
    {1'b1, 8'h05, 8'hFF, 8'h00}, {1'b1, 8'h05, 8'h01, 8'h00},
    {1'b0, 8'h04, 8'h00, 8'hCD}, {1'b0, 8'h04, 8'h00, 8'hAB},
    {1'b0, 8'h05, 8'h00, 8'hFF}, {1'b0, 8'h05, 8'h00, 8'h01},
    {1'b0, 8'h02, 8'h00, 8'h00}, {1'b0, 8'h02, 8'h00, 8'h00},
    {1'b1, 8'h16, 8'h55, 8'h00}, {1'b1, 8'h16, 8'hAA, 8'h00},
    {1'b0, 8'h06, 8'h00, 8'h55}, {1'b0, 8'h06, 8'h00, 8'hAA}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic io_en = 1'b0, io_wr = 1'b0, ff_clr = 1'b0;
  logic [7:0] io_port = '0, io_wdata = '0;
  logic [3:0] dir_down = '0, pos_we = '0, addr_we = '0;
  logic [4*POS_W-1:0] pos_in = '0;
  logic [4*CUR_W-1:0] addr_in = '0;
  logic [7:0] rd_data;
  logic rd_valid;
  logic [4*CUR_W-1:0] cur_addr_o;
  logic [4*POS_W-1:0] pos_o;
  logic [63:0] base_cnt_o;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  dma_chan_regfile #(.SHIFT(SHIFT)) dut (
    .clk(clk), .rst(rst), .io_en(io_en), .io_wr(io_wr), .io_port(io_port),
    .io_wdata(io_wdata), .ff_clr(ff_clr), .dir_down(dir_down), .pos_we(pos_we),
    .pos_in(pos_in), .addr_we(addr_we), .addr_in(addr_in), .rd_data(rd_data),
    .rd_valid(rd_valid), .cur_addr_o(cur_addr_o), .pos_o(pos_o),
    .base_cnt_o(base_cnt_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [7:0] port, input logic [7:0] data);
    @(negedge clk);
    io_en = 1'b1; io_wr = wr; io_port = port; io_wdata = data;
    @(negedge clk);
    io_en = 1'b0; io_wr = 1'b0;
  endtask

  task automatic rd_check(input logic [7:0] port, input logic [7:0] exp, input string req);
    access(1'b0, port, 8'h00);
    check(req, {31'd0, rd_valid}, 32'd1);
    check(req, {24'd0, rd_data}, {24'd0, exp});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 cur_addr", cur_addr_o, '0);
    check("R10 pos", pos_o[31:0], '0);
    check("R10 rd_valid", {31'd0, rd_valid}, 32'd0);
    rst = 1'b0;

    // R1 R2 R4 R5 R8: decode and byte pointer via table
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][24]) access(1'b1, VEC[i][23:16], VEC[i][15:8]);
      else rd_check(VEC[i][23:16], VEC[i][7:0], "R1/R2 table read");
    end

    // R9 R6: position hook, incrementing
    @(negedge clk); pos_we = 4'b0001; pos_in[POS_W-1:0] = POS_W'(5);
    @(negedge clk); pos_we = '0;
    rd_check(8'h00, 8'h39, "R6 up low");
    rd_check(8'h00, 8'h12, "R6 up high");
    // R7: remaining count
    rd_check(8'h01, 8'h0B, "R7 low");
    rd_check(8'h01, 8'h00, "R7 high");
    // R6: decrementing
    dir_down = 4'b0001;
    rd_check(8'h00, 8'h2F, "R6 down low");
    rd_check(8'h00, 8'h12, "R6 down high");

    // R3: clear between halves
    rd_check(8'h00, 8'h2F, "R3 first low");
    @(negedge clk); ff_clr = 1'b1;
    @(negedge clk); ff_clr = 1'b0;
    rd_check(8'h00, 8'h2F, "R3 low again");
    rd_check(8'h00, 8'h12, "R3 realign");

    // R1: index bit 3 set is ignored
    access(1'b1, 8'h08, 8'hEE);
    check("R1 no rd_valid", {31'd0, rd_valid}, 32'd0);
    check("R1 ch0 addr kept", {16'd0, cur_addr_o[15:0]}, 32'h1234);
    rd_check(8'h00, 8'h2F, "R1 pointer kept");
    rd_check(8'h00, 8'h12, "R1 realign");

    // R4: low write keeps high byte, no reload
    @(negedge clk); pos_we = 4'b0100; pos_in[2*POS_W +: POS_W] = POS_W'(9);
    @(negedge clk); pos_we = '0;
    access(1'b1, 8'h05, 8'h77);
    check("R4 base cnt", {16'd0, base_cnt_o[47:32]}, 32'h0177);
    check("R4 pos kept", {15'd0, pos_o[2*POS_W +: POS_W]}, 32'd9);
    // R5: high write reloads
    access(1'b1, 8'h05, 8'h02);
    check("R5 base cnt", {16'd0, base_cnt_o[47:32]}, 32'h0277);
    check("R5 pos cleared", {15'd0, pos_o[2*POS_W +: POS_W]}, 32'd0);
    check("R5 cur addr", {16'd0, cur_addr_o[2*CUR_W +: CUR_W]}, 32'hABCD);

    // R9: address hook
    @(negedge clk); addr_we = 4'b0010; addr_in[CUR_W +: CUR_W] = 16'h0100;
    @(negedge clk); addr_we = '0;
    rd_check(8'h02, 8'h00, "R9 addr hook low");
    rd_check(8'h02, 8'h01, "R9 addr hook high");

    // R9: high write beats a same-cycle position hook
    access(1'b1, 8'h00, 8'h00);
    @(negedge clk);
    io_en = 1'b1; io_wr = 1'b1; io_port = 8'h00; io_wdata = 8'h40;
    pos_we = 4'b0001; pos_in[POS_W-1:0] = POS_W'(7);
    @(negedge clk);
    io_en = 1'b0; io_wr = 1'b0; pos_we = '0;
    check("R9 priority pos", {15'd0, pos_o[POS_W-1:0]}, 32'd0);
    check("R9 priority addr", {16'd0, cur_addr_o[CUR_W-1:0]}, 32'h4000);

    // R10: reset again mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R10 re-reset addr", cur_addr_o, '0);
    check("R10 re-reset cnt", base_cnt_o[31:0], '0);
    rd_check(8'h00, 8'h00, "R10 read after reset");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule